// File: doc/BRIEF.md
# USB Wrapper Interrupt Aggregator

This block is the register shell placed between a USB controller core and the host CPU. It latches single-cycle event pulses from the core into two status words. One word covers the endpoints: transmit events sit in the low half and receive events in the high half. The other word covers the core-level events. Each word has an enable mask. Software grows a mask by writing ones to a set address and shrinks it by writing ones to a clear address. Any pending status bit whose enable is on drives the single interrupt line.

Software clears a pending bit by writing a one to it. The block also generates one core event itself: every change in the level of the VBUS drive request latches bit 8 of the core word. Three configuration registers complete the block. The control register drives a soft reset to the core. The mode register can override the ID pin seen by the core with a value chosen by software. The PHY register holds an OTG-disable bit, which comes out of reset set; software must clear it before host operation.

Accesses use a simple request/acknowledge bus with 32-bit data. A sequencer with three states serves each access. **BUS_IDLE** waits for a request and latches the address, direction and write data. On a read request it moves to **BUS_RD**, where the read data is presented together with the acknowledge. On a write request it moves to **BUS_WR**, where the acknowledge is raised and the write takes effect on the edge that leaves the state. Both BUS_RD and BUS_WR always return to BUS_IDLE.

Top module: `usb_irq_agg`

## Requirements
- R1: After reset, the status words and enable masks read 0, the interrupt is low, the soft reset output is low, OTG-disable is high, and offset 0x00 reads the nonzero constant REV_ID.
- R2: Transmit event i latches bit i of the endpoint status word at 0x30. Receive event j latches bit 16+j. Receive bit 0 (bit 16) is not implemented: it always reads 0 in the status word and in the enable mask.
- R3: Core events 7..0 latch bits 7..0 of the core status word at 0x34. Bit 8 latches on each rising and each falling change of the VBUS drive request. Bits 31..9 read 0.
- R4: Writing to 0x30 or 0x34 clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R5: A write to 0x38 (endpoint) or 0x3C (core) ORs the data into that enable mask. A write to 0x40 (endpoint) or 0x44 (core) removes the written bits from it. Both the set offset and the clear offset of a mask read its current value.
- R6: irq_o is high exactly when some status bit in either word is set and its enable bit is set. It follows the registered status and masks with no added delay.
- R7: An event that arrives in the same cycle as a write that clears its bit wins: the bit stays set.
- R8: Bit 0 of the control register at 0x14 drives core_reset_o and reads back.
- R9: In the mode register at 0xE8, bit 7 selects the software ID value held in bit 8. When bit 7 is clear, id_o follows phy_id_i.
- R10: Bit 21 of the PHY register at 0xE0 drives otg_disable_o and reads back. It changes only when 0xE0 is written.
- R11: Bit 0 of offset 0x18 returns the VBUS drive request level, registered one cycle.
- R12: Each request is acknowledged for exactly one cycle, in the cycle after it is accepted. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle acknowledge |
| tx_evt | input | NUM_EP | Transmit endpoint event pulses |
| rx_evt | input | NUM_EP | Receive endpoint event pulses (bit 0 ignored) |
| core_evt | input | CORE_EVT | Core event pulses |
| vbus_req_i | input | 1 | VBUS drive request level |
| phy_id_i | input | 1 | ID pin from the PHY |
| irq_o | output | 1 | Combined interrupt |
| core_reset_o | output | 1 | Soft reset to the core |
| id_o | output | 1 | ID value passed to the core |
| otg_disable_o | output | 1 | OTG-disable to the PHY |

## Verification
An event pulse that is present before a clock edge shows up in the status word, and in irq_o, right after that edge. A VBUS level change shows up in status bit 8 and in the 0x18 level after the following edge. A write takes effect on the second edge after the request is raised, while read data and the acknowledge are valid between the first and second edges. The bench therefore drives every input on the falling edge and samples at a later falling edge: status one falling edge after a pulse, read data at the acknowledge falling edge, and write effects one falling edge after that. The single corner that depends on timing is the event-against-clear race. It is forced by raising the event exactly in the acknowledge cycle of the clearing write.

// File: rtl/usbw_pkg.sv
package usbw_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WR   = 2'd2
    } bus_state_e;

    localparam logic [7:0] OFF_REV      = 8'h00;
    localparam logic [7:0] OFF_CTRL     = 8'h14;
    localparam logic [7:0] OFF_LEVEL    = 8'h18;
    localparam logic [7:0] OFF_EP_STAT  = 8'h30;
    localparam logic [7:0] OFF_CR_STAT  = 8'h34;
    localparam logic [7:0] OFF_EP_SET   = 8'h38;
    localparam logic [7:0] OFF_CR_SET   = 8'h3C;
    localparam logic [7:0] OFF_EP_CLR   = 8'h40;
    localparam logic [7:0] OFF_CR_CLR   = 8'h44;
    localparam logic [7:0] OFF_PHY      = 8'hE0;
    localparam logic [7:0] OFF_MODE     = 8'hE8;

    localparam int CTRL_RST_BIT  = 0;
    localparam int MODE_SEL_BIT  = 7;
    localparam int MODE_VAL_BIT  = 8;
    localparam int PHY_OTGD_BIT  = 21;

endpackage

// File: rtl/usbw_bus_fsm.sv
module usbw_bus_fsm
    import usbw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o
);

    bus_state_e state_q, state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = we_i ? BUS_WR : BUS_RD;
            BUS_RD:   state_d = BUS_IDLE;
            BUS_WR:   state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= BUS_IDLE;
            addr_q_o  <= '0;
            wdata_q_o <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BUS_IDLE && req_i) begin
                addr_q_o  <= addr_i;
                wdata_q_o <= wdata_i;
            end
        end
    end

    // outputs per state
    always_comb begin
        ack_o   = 1'b0;
        rd_en_o = 1'b0;
        wr_en_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_RD: begin
                ack_o   = 1'b1;
                rd_en_o = 1'b1;
            end
            BUS_WR: begin
                ack_o   = 1'b1;
                wr_en_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usbw_evt_bank.sv
module usbw_evt_bank #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         stat_clr_we,
    input  logic         en_set_we,
    input  logic         en_clr_we,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL[b]) begin : g_impl
            logic s_q, e_q;
            // a fresh event is ORed in after the clear, so it wins
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= (s_q & ~(stat_clr_we & wdata_i[b])) | evt_i[b];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        e_q <= 1'b0;
                else if (en_set_we && wdata_i[b])  e_q <= 1'b1;
                else if (en_clr_we && wdata_i[b])  e_q <= 1'b0;
            end
            assign stat_o[b] = s_q;
            assign en_o[b]   = e_q;
        end else begin : g_tie
            assign stat_o[b] = 1'b0;
            assign en_o[b]   = 1'b0;
        end
    end

    assign pend_o = |(stat_o & en_o);

    logic unused_bits;
    assign unused_bits = ^((evt_i | wdata_i) & ~IMPL);

endmodule

// File: rtl/usbw_cfg_regs.sv
module usbw_cfg_regs
    import usbw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              mode_we,
    input  logic              phy_we,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              vbus_req_i,
    input  logic              phy_id_i,
    output logic              core_reset_o,
    output logic              mode_sel_o,
    output logic              mode_val_o,
    output logic              otg_dis_o,
    output logic              id_o,
    output logic              vbus_lvl_o,
    output logic              vbus_chg_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_reset_o <= 1'b0;
            mode_sel_o   <= 1'b0;
            mode_val_o   <= 1'b0;
            otg_dis_o    <= 1'b1;
            vbus_lvl_o   <= 1'b0;
        end else begin
            vbus_lvl_o <= vbus_req_i;
            if (ctrl_we) core_reset_o <= wdata_i[CTRL_RST_BIT];
            if (mode_we) begin
                mode_sel_o <= wdata_i[MODE_SEL_BIT];
                mode_val_o <= wdata_i[MODE_VAL_BIT];
            end
            if (phy_we) otg_dis_o <= wdata_i[PHY_OTGD_BIT];
        end
    end

    assign vbus_chg_o = vbus_req_i ^ vbus_lvl_o;
    assign id_o       = mode_sel_o ? mode_val_o : phy_id_i;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
    import usbw_pkg::*;
#(
    parameter int          NUM_EP   = 16,
    parameter int          CORE_EVT = 8,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] REV_ID   = 32'h5A31_0C02
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ack,
    input  logic [NUM_EP-1:0]   tx_evt,
    input  logic [NUM_EP-1:0]   rx_evt,
    input  logic [CORE_EVT-1:0] core_evt,
    input  logic                vbus_req_i,
    input  logic                phy_id_i,
    output logic                irq_o,
    output logic                core_reset_o,
    output logic                id_o,
    output logic                otg_disable_o
);

    localparam int DATA_W = 32;
    localparam int EP_W   = 2 * NUM_EP;
    localparam int CR_W   = CORE_EVT + 1;
    localparam logic [EP_W-1:0] EP_IMPL = {{(NUM_EP-1){1'b1}}, 1'b0, {NUM_EP{1'b1}}};
    localparam logic [CR_W-1:0] CR_IMPL = '1;

    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    usbw_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .ack_o     (bus_ack),
        .rd_en_o   (rd_en),
        .wr_en_o   (wr_en),
        .addr_q_o  (addr_q),
        .wdata_q_o (wdata_q)
    );

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic we_ep_stat, we_ep_set, we_ep_clr;
    logic we_cr_stat, we_cr_set, we_cr_clr;
    logic we_ctrl, we_mode, we_phy;

    always_comb begin
        we_ep_stat = wr_en && hit(addr_q, OFF_EP_STAT);
        we_ep_set  = wr_en && hit(addr_q, OFF_EP_SET);
        we_ep_clr  = wr_en && hit(addr_q, OFF_EP_CLR);
        we_cr_stat = wr_en && hit(addr_q, OFF_CR_STAT);
        we_cr_set  = wr_en && hit(addr_q, OFF_CR_SET);
        we_cr_clr  = wr_en && hit(addr_q, OFF_CR_CLR);
        we_ctrl    = wr_en && hit(addr_q, OFF_CTRL);
        we_mode    = wr_en && hit(addr_q, OFF_MODE);
        we_phy     = wr_en && hit(addr_q, OFF_PHY);
    end

    logic              mode_sel, mode_val, vbus_lvl, vbus_chg;

    usbw_cfg_regs #(.DATA_W(DATA_W)) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (we_ctrl),
        .mode_we      (we_mode),
        .phy_we       (we_phy),
        .wdata_i      (wdata_q),
        .vbus_req_i   (vbus_req_i),
        .phy_id_i     (phy_id_i),
        .core_reset_o (core_reset_o),
        .mode_sel_o   (mode_sel),
        .mode_val_o   (mode_val),
        .otg_dis_o    (otg_disable_o),
        .id_o         (id_o),
        .vbus_lvl_o   (vbus_lvl),
        .vbus_chg_o   (vbus_chg)
    );

    logic [EP_W-1:0] ep_stat, ep_en;
    logic [CR_W-1:0] core_stat, core_en;
    logic            ep_pend, core_pend;

    usbw_evt_bank #(.W(EP_W), .IMPL(EP_IMPL)) i_ep_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       ({rx_evt, tx_evt}),
        .stat_clr_we (we_ep_stat),
        .en_set_we   (we_ep_set),
        .en_clr_we   (we_ep_clr),
        .wdata_i     (wdata_q[EP_W-1:0]),
        .stat_o      (ep_stat),
        .en_o        (ep_en),
        .pend_o      (ep_pend)
    );

    usbw_evt_bank #(.W(CR_W), .IMPL(CR_IMPL)) i_core_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       ({vbus_chg, core_evt}),
        .stat_clr_we (we_cr_stat),
        .en_set_we   (we_cr_set),
        .en_clr_we   (we_cr_clr),
        .wdata_i     (wdata_q[CR_W-1:0]),
        .stat_o      (core_stat),
        .en_o        (core_en),
        .pend_o      (core_pend)
    );

    assign irq_o = ep_pend | core_pend;

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (addr_q)
            ADDR_W'(OFF_REV):     rd_mux = REV_ID;
            ADDR_W'(OFF_CTRL):    rd_mux[CTRL_RST_BIT] = core_reset_o;
            ADDR_W'(OFF_LEVEL):   rd_mux[0] = vbus_lvl;
            ADDR_W'(OFF_EP_STAT): rd_mux = DATA_W'(ep_stat);
            ADDR_W'(OFF_CR_STAT): rd_mux = DATA_W'(core_stat);
            ADDR_W'(OFF_EP_SET),
            ADDR_W'(OFF_EP_CLR):  rd_mux = DATA_W'(ep_en);
            ADDR_W'(OFF_CR_SET),
            ADDR_W'(OFF_CR_CLR):  rd_mux = DATA_W'(core_en);
            ADDR_W'(OFF_PHY):     rd_mux[PHY_OTGD_BIT] = otg_disable_o;
            ADDR_W'(OFF_MODE): begin
                rd_mux[MODE_SEL_BIT] = mode_sel;
                rd_mux[MODE_VAL_BIT] = mode_val;
            end
            default:              rd_mux = '0;
        endcase
    end

    assign bus_rdata = rd_en ? rd_mux : '0;

endmodule

// File: rtl/usbw_irq_agg_chk.sv
module usbw_irq_agg_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ack,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr_q,
    input logic              wdata_b0,
    input logic              tx_evt0,
    input logic              ep_stat0,
    input logic              ep_en0,
    input logic              vbus_req_i,
    input logic              core_stat8,
    input logic              irq_o,
    input logic              otg_disable_o
);

    logic clr_ep0;
    assign clr_ep0 = wr_en && (addr_q == ADDR_W'(8'h30)) && wdata_b0;

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ep0 && !tx_evt0) |=> !ep_stat0);

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ep0 && tx_evt0) |=> ep_stat0);

    assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt0 && ep_en0 && !wr_en) |=> irq_o);

    assert_vbus_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbus_req_i) |=> core_stat8);

    assert_ack_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_otg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_q == ADDR_W'(8'hE0)) |=> $stable(otg_disable_o));

endmodule

bind usb_irq_agg usbw_irq_agg_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_ack       (bus_ack),
    .wr_en         (wr_en),
    .addr_q        (addr_q),
    .wdata_b0      (wdata_q[0]),
    .tx_evt0       (tx_evt[0]),
    .ep_stat0      (ep_stat[0]),
    .ep_en0        (ep_en[0]),
    .vbus_req_i    (vbus_req_i),
    .core_stat8    (core_stat[8]),
    .irq_o         (irq_o),
    .otg_disable_o (otg_disable_o)
);

// File: tb/test_usb_irq_agg.sv
`timescale 1ns/1ps
module test_usb_irq_agg;

    localparam logic [31:0] REV  = 32'h5A31_0C02;
    localparam logic [31:0] EPM  = 32'hFFFE_FFFF;
    localparam logic [31:0] CRM  = 32'h0000_01FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [15:0] tx_evt = '0, rx_evt = '0;
    logic [7:0]  core_evt = '0;
    logic        vbus_req_i = 1'b0, phy_id_i = 1'b1;
    logic        irq_o, core_reset_o, id_o, otg_disable_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ep, m_ep_en, m_cr, m_cr_en;

    always #2.5 clk = ~clk;

    usb_irq_agg i_usb_irq_agg (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
        .vbus_req_i(vbus_req_i), .phy_id_i(phy_id_i),
        .irq_o(irq_o), .core_reset_o(core_reset_o), .id_o(id_o),
        .otg_disable_o(otg_disable_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_ep & m_ep_en) || |(m_cr & m_cr_en);
    endfunction

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk("R12 ack", 32'(bus_ack), 32'd1);
        r = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
        chk("R12 ack drop", 32'(bus_ack), 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r;
        xfer(1'b0, a, 32'h0, r);
        chk(rq, r, exp);
    endtask

    task automatic pulse(input logic [15:0] t, input logic [15:0] rx, input logic [7:0] c);
        @(negedge clk);
        tx_evt = t; rx_evt = rx; core_evt = c;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; core_evt = '0;
        m_ep = m_ep | ({rx, t} & EPM);
        m_cr = m_cr | {24'h0, c};
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_ep = '0; m_ep_en = '0; m_cr = '0; m_cr_en = '0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 core_reset", 32'(core_reset_o), 0);
        chk("R1 otg_disable", 32'(otg_disable_o), 1);
        rd_chk("R1 revision", 8'h00, REV);
        rd_chk("R1 ep status", 8'h30, 0);
        rd_chk("R1 core status", 8'h34, 0);
        rd_chk("R1 ep enable", 8'h38, 0);

        // R2 endpoint packing, receive bit 0 absent
        pulse(16'h8001, 16'h0003, 8'h00);
        rd_chk("R2 ep status", 8'h30, 32'h0002_8001);
        chk("R6 irq masked", 32'(irq_o), 0);
        wr(8'h38, 32'hFFFF_FFFF); m_ep_en = EPM;
        rd_chk("R2 R5 enable set", 8'h38, 32'hFFFE_FFFF);
        rd_chk("R5 enable via clear offset", 8'h40, 32'hFFFE_FFFF);
        chk("R6 irq on", 32'(irq_o), 1);
        wr(8'h40, 32'hFFFF_7FFE); m_ep_en = 32'h0000_8001;
        rd_chk("R5 enable clear", 8'h38, 32'h0000_8001);
        wr(8'h40, 32'hFFFF_FFFF); m_ep_en = 0;
        chk("R6 irq off", 32'(irq_o), 0);

        // R4 write-one-to-clear
        wr(8'h30, 32'h0000_8000); m_ep = 32'h0002_0001;
        rd_chk("R4 partial clear", 8'h30, 32'h0002_0001);
        wr(8'h30, 32'hFFFF_FFFF); m_ep = 0;
        rd_chk("R4 full clear", 8'h30, 0);

        // R7 event in the commit cycle of a clear
        pulse(16'h0008, 16'h0, 8'h0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_req = 1'b0; tx_evt = 16'h0008;
        @(negedge clk);
        tx_evt = '0;
        rd_chk("R7 event beats clear", 8'h30, 32'h0000_0008);
        wr(8'h30, 32'h0000_0008); m_ep = 0;
        rd_chk("R7 later clear works", 8'h30, 0);

        // R3 core word and VBUS change, R11 level
        pulse(16'h0, 16'h0, 8'hA5);
        rd_chk("R3 core events", 8'h34, 32'h0000_00A5);
        @(negedge clk); vbus_req_i = 1'b1;
        @(negedge clk);
        rd_chk("R3 vbus rise", 8'h34, 32'h0000_01A5);
        rd_chk("R11 level high", 8'h18, 32'h1);
        wr(8'h34, 32'hFFFF_FFFF); m_cr = 0;
        rd_chk("R4 core clear", 8'h34, 0);
        wr(8'h3C, 32'h0000_0100); m_cr_en = 32'h100;
        chk("R6 no pending core", 32'(irq_o), 0);
        @(negedge clk); vbus_req_i = 1'b0;
        @(negedge clk);
        chk("R3 R6 vbus fall irq", 32'(irq_o), 1);
        rd_chk("R11 level low", 8'h18, 32'h0);
        rd_chk("R5 core enable", 8'h44, 32'h100);
        wr(8'h44, 32'h100); m_cr_en = 0;
        wr(8'h34, 32'h100); m_cr = 0;

        // R8 soft reset
        wr(8'h14, 32'h1);
        chk("R8 reset out", 32'(core_reset_o), 1);
        rd_chk("R8 readback", 8'h14, 32'h1);
        wr(8'h14, 32'h0);
        chk("R8 reset off", 32'(core_reset_o), 0);

        // R9 ID override
        wr(8'hE8, 32'h0);
        phy_id_i = 1'b1; @(negedge clk);
        chk("R9 follow phy 1", 32'(id_o), 1);
        phy_id_i = 1'b0; @(negedge clk);
        chk("R9 follow phy 0", 32'(id_o), 0);
        wr(8'hE8, 32'h180);
        chk("R9 forced 1", 32'(id_o), 1);
        rd_chk("R9 readback", 8'hE8, 32'h180);
        wr(8'hE8, 32'h080);
        phy_id_i = 1'b1; @(negedge clk);
        chk("R9 forced 0", 32'(id_o), 0);

        // R10 OTG disable
        wr(8'hE0, 32'h0);
        chk("R10 cleared", 32'(otg_disable_o), 0);
        rd_chk("R10 readback 0", 8'hE0, 0);
        wr(8'hE0, 32'h0020_0000);
        chk("R10 set", 32'(otg_disable_o), 1);

        // R12 unmapped
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped read", 8'h04, 0);
        rd_chk("R12 unmapped no effect", 8'h30, 0);

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 5);
            d  = $urandom;
            case (op)
                0: begin
                    logic [15:0] t, rx;
                    logic [7:0] c;
                    t = 16'($urandom); rx = 16'($urandom); c = 8'($urandom);
                    pulse(t, rx, c);
                end
                1: begin
                    if (d[0]) begin wr(8'h38, d); m_ep_en = m_ep_en | (d & EPM); end
                    else begin wr(8'h3C, d); m_cr_en = m_cr_en | (d & CRM); end
                end
                2: begin
                    if (d[0]) begin wr(8'h40, d); m_ep_en = m_ep_en & ~d; end
                    else begin wr(8'h44, d); m_cr_en = m_cr_en & ~d; end
                end
                3: begin
                    if (d[1]) begin wr(8'h30, d); m_ep = m_ep & ~d; end
                    else begin wr(8'h34, d); m_cr = m_cr & ~d; end
                end
                default: begin
                    @(negedge clk); vbus_req_i = ~vbus_req_i;
                    @(negedge clk);
                    m_cr = m_cr | 32'h100;
                end
            endcase
            chk("R6 random irq", 32'(irq_o), 32'(exp_irq()));
            if (it % 4 == 0) begin
                rd_chk("R2 R4 random ep", 8'h30, m_ep);
                rd_chk("R3 R4 random core", 8'h34, m_cr);
                rd_chk("R5 random ep en", 8'h40, m_ep_en);
                rd_chk("R5 random core en", 8'h3C, m_cr_en);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule